// File: doc/BRIEF.md
# Accumulator Processor Core

A small single-accumulator processor. Each instruction is a 16-bit word, and the core addresses 4096 words of external memory. The memory answers a read combinationally in the same cycle and takes a write on the rising clock edge.

The core keeps a 16-bit accumulator, a one-bit extension flag, a 12-bit program counter, a 12-bit address register, an instruction register and an interrupt-enable flip-flop. It fetches, decodes and executes instructions in a multi-cycle sequence. There are three instruction groups:
- memory operations, with direct or indirect addressing;
- register operations, each selected by a single bit;
- character input and output operations, each selected by a single bit.

A character device sits outside the core and owns two ready flags, one for input and one for output. The core reads both flags. It pulses a strobe when it takes an input character, and another when it presents an output character. The device clears the matching flag on that strobe.

Top module: `acc16_core`

## Requirements
- R1: While `rst_n` is low and at the first cycle after it rises, the core is in the following state:
  - `mem_addr` is 0 and `mem_we` is 0;
  - `halted`, `ien` and `out_char` are 0;
  - the accumulator and extension flag are 0;
  - the first fetch reads address 0.
- R2: The instruction word has three fields:
  - bit 15 is the mode bit (0 direct, 1 indirect);
  - bits 14..12 are the opcode;
  - bits 11..0 are the address.

  Opcodes 0 to 6 are AND, ADD, load, store, branch, branch-and-save and increment-skip-if-zero. Opcode 7 with mode 0 selects the register group; opcode 7 with mode 1 selects the I/O group.
- R3: The accumulator operations work as follows:
  - AND replaces the accumulator with its bitwise AND with the memory word;
  - ADD replaces it with the 16-bit sum and puts the carry out of bit 15 into the extension flag;
  - load copies the word into the accumulator;
  - store writes the accumulator to memory.
- R4: In indirect mode the core makes one extra read at the 12-bit address. The low 12 bits of that word become the effective address, and the upper 4 bits are ignored. Register and I/O instructions never make this read.
- R5: Branch loads the effective address into the PC. Branch-and-save writes the address of the following word into memory at the effective address, then continues at the effective address plus one. An indirect branch through that word returns to the caller.
- R6: Increment-skip-if-zero adds one to the memory word and writes it back. When the new value is 0, the next instruction is skipped.
- R7: The register group has these encodings:
  - 7800 clears the accumulator; 7400 clears the extension flag;
  - 7200 complements the accumulator; 7100 complements the extension flag;
  - 7080 rotates right through the extension flag, and 7040 rotates left through it; each rotate moves the outgoing end bit into the flag and the old flag into the vacated end;
  - 7020 increments the accumulator and leaves the flag unchanged.
- R8: The conditional skips are 7010, 7008, 7004 and 7002. They skip when, respectively, accumulator bit 15 is 0 (so zero counts as positive), bit 15 is 1, the accumulator is 0, and the extension flag is 0. A skip adds one extra increment to the PC.
- R9: F800 loads `in_char` into accumulator bits 7..0, leaves bits 15..8 unchanged, and pulses `in_take` for one cycle. F400 loads accumulator bits 7..0 into `out_char` and pulses `out_put` for one cycle. `out_char` changes only after such a pulse.
- R10: F200 skips only while `in_flag` is 1, and F100 skips only while `out_flag` is 1.
- R11: F080 sets `ien` and F040 clears it. No other instruction changes `ien`.
- R12: 7001 halts the core. After that, `halted` stays 1 with no memory write, no strobe and no further execution until reset.
- R13: If a register or I/O word has several bits of 11..0 set, only the highest set bit takes effect.
- R14: Each instruction takes a fixed number of cycles:
  - a register or I/O instruction takes 2;
  - a direct memory instruction takes 3, and indirect mode adds 1;
  - increment-skip-if-zero adds 1 more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 12 | Memory word address |
| mem_rdata | input | 16 | Memory read data, valid in the same cycle |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write enable, applied at the rising edge |
| in_char | input | 8 | Input character |
| in_flag | input | 1 | Input character ready |
| in_take | output | 1 | One-cycle pulse when the input character is taken |
| out_char | output | 8 | Output character register |
| out_flag | input | 1 | Output device ready |
| out_put | output | 1 | One-cycle pulse when a new output character is presented |
| ien | output | 1 | Interrupt-enable flip-flop |
| halted | output | 1 | Core has executed halt |

## Verification
The bench sweeps ADD and AND over operand pairs that do and do not carry out of bit 15, and sweeps every rotate, complement and increment with the extension flag at 0 and at 1. A core that dropped the carry, or that rotated without passing through the flag, would store a wrong accumulator or flag word.

The skip sweep aims at the zero and 8000 accumulator values and at both flag values. A core that treated zero as non-positive, or that skipped on the wrong polarity, would store the value of the instruction it should have skipped, or the reverse.

Indirect pointers carry non-zero upper bits, so a core that used the whole pointer word would miss its target. Cycle counts from reset to halt expose any extra or missing pointer read. A loop that counts up to zero, and a call-and-return pair, show whether the skip after increment and the return address are off by one.

The I/O program spins on both ready flags before they rise and checks that the input keeps the accumulator's upper byte. Multi-bit words show whether more than one operation fired, and a halt followed by a store shows whether execution leaked past halt.

// File: rtl/acc16_core.sv
module acc16_core (
  input  logic        clk,
  input  logic        rst_n,
  output logic [11:0] mem_addr,
  input  logic [15:0] mem_rdata,
  output logic [15:0] mem_wdata,
  output logic        mem_we,
  input  logic [7:0]  in_char,
  input  logic        in_flag,
  output logic        in_take,
  output logic [7:0]  out_char,
  input  logic        out_flag,
  output logic        out_put,
  output logic        ien,
  output logic        halted
);

  typedef enum logic [2:0] {S_FETCH, S_DECODE, S_INDIR, S_EXEC, S_ISZW, S_HALT} state_t;

  localparam logic [2:0] OP_AND = 3'd0, OP_ADD = 3'd1, OP_LDA = 3'd2, OP_STA = 3'd3,
                         OP_BUN = 3'd4, OP_BSA = 3'd5, OP_ISZ = 3'd6, OP_GRP = 3'd7;

  state_t      state;
  logic [15:0] ac, ir, dr;
  logic        e;
  logic [11:0] pc, ar;

  wire [2:0] opc    = ir[14:12];
  wire       ind    = ir[15];
  wire       grp    = (opc == OP_GRP);
  wire       io_op  = grp && ind;
  wire       decode = (state == S_DECODE);

  assign mem_addr  = (state == S_FETCH) ? pc : ar;
  assign mem_we    = ((state == S_EXEC) && (opc == OP_STA || opc == OP_BSA)) || (state == S_ISZW);
  assign mem_wdata = (state == S_ISZW) ? dr : ((opc == OP_BSA) ? {4'h0, pc} : ac);
  assign halted    = (state == S_HALT);
  assign in_take   = decode && io_op && ir[11];
  assign out_put   = decode && io_op && !ir[11] && ir[10];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_FETCH;
      ac       <= '0;
      ir       <= '0;
      dr       <= '0;
      e        <= 1'b0;
      pc       <= '0;
      ar       <= '0;
      ien      <= 1'b0;
      out_char <= '0;
    end else begin
      case (state)
        S_FETCH: begin
          ir    <= mem_rdata;
          pc    <= pc + 12'd1;
          state <= S_DECODE;
        end
        S_DECODE: begin
          if (grp) begin
            state <= S_FETCH;
            if (!ind) begin
              if (ir[11])      ac <= '0;
              else if (ir[10]) e  <= 1'b0;
              else if (ir[9])  ac <= ~ac;
              else if (ir[8])  e  <= ~e;
              else if (ir[7]) begin ac <= {e, ac[15:1]}; e <= ac[0];  end
              else if (ir[6]) begin ac <= {ac[14:0], e}; e <= ac[15]; end
              else if (ir[5])  ac <= ac + 16'd1;
              else if (ir[4]) begin if (!ac[15])     pc <= pc + 12'd1; end
              else if (ir[3]) begin if (ac[15])      pc <= pc + 12'd1; end
              else if (ir[2]) begin if (ac == 16'd0) pc <= pc + 12'd1; end
              else if (ir[1]) begin if (!e)          pc <= pc + 12'd1; end
              else if (ir[0])  state <= S_HALT;
            end else begin
              if (ir[11])      ac[7:0]  <= in_char;
              else if (ir[10]) out_char <= ac[7:0];
              else if (ir[9]) begin if (in_flag)  pc <= pc + 12'd1; end
              else if (ir[8]) begin if (out_flag) pc <= pc + 12'd1; end
              else if (ir[7])  ien <= 1'b1;
              else if (ir[6])  ien <= 1'b0;
            end
          end else begin
            ar    <= ir[11:0];
            state <= ind ? S_INDIR : S_EXEC;
          end
        end
        S_INDIR: begin
          ar    <= mem_rdata[11:0];
          state <= S_EXEC;
        end
        S_EXEC: begin
          state <= S_FETCH;
          case (opc)
            OP_AND: ac <= ac & mem_rdata;
            OP_ADD: {e, ac} <= {1'b0, ac} + {1'b0, mem_rdata};
            OP_LDA: ac <= mem_rdata;
            OP_BUN: pc <= ar;
            OP_BSA: pc <= ar + 12'd1;
            OP_ISZ: begin
              dr    <= mem_rdata + 16'd1;
              state <= S_ISZW;
            end
            default: ;
          endcase
        end
        S_ISZW: begin
          if (dr == 16'd0) pc <= pc + 12'd1;
          state <= S_FETCH;
        end
        default: state <= S_HALT;
      endcase
    end
  end

endmodule

// File: rtl/acc16_core_chk.sv
module acc16_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] mem_addr,
  input logic        mem_we,
  input logic        in_take,
  input logic        out_put,
  input logic [7:0]  out_char,
  input logic        ien,
  input logic        halted,
  input logic [15:0] ir
);

  AST_RESET_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mem_addr == 12'd0) && !mem_we && !ien && !halted);  // R1

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);  // R12

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we && !in_take && !out_put);  // R12

  AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);  // R14

  AST_IO_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_take, out_put}));  // R13

  AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    in_take |=> !in_take);  // R9

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_char) |-> $past(out_put));  // R9

  AST_IEN_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ien) |-> ($past(ir[15:12]) == 4'hF));  // R11

endmodule

bind acc16_core acc16_core_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
  .in_take(in_take), .out_put(out_put), .out_char(out_char),
  .ien(ien), .halted(halted), .ir(ir)
);

// File: tb/acc16_core_tb_top.sv
`timescale 1ns/1ps
module acc16_core_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr;
  logic [15:0] mem_rdata, mem_wdata;
  logic        mem_we;
  logic [7:0]  in_char = 8'h00;
  logic        in_flag, out_flag;
  logic        in_take, out_put, ien, halted;
  logic [7:0]  out_char;

  logic [15:0] mem [0:4095];
  logic        ld_en = 1'b0;
  logic [11:0] ld_a = '0;
  logic [15:0] ld_d = '0;
  logic        in_set = 1'b0, out_set = 1'b0;
  int          wr_cnt, take_cnt, put_cnt;
  logic        ien_seen;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  acc16_core dut_i (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .in_char(in_char), .in_flag(in_flag),
    .in_take(in_take), .out_char(out_char), .out_flag(out_flag), .out_put(out_put),
    .ien(ien), .halted(halted)
  );

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (ld_en) mem[ld_a] <= ld_d;
    else if (mem_we && rst_n) mem[mem_addr] <= mem_wdata;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_flag <= 1'b0; out_flag <= 1'b0;
      wr_cnt <= 0; take_cnt <= 0; put_cnt <= 0; ien_seen <= 1'b0;
    end else begin
      if (in_set) in_flag <= 1'b1; else if (in_take) in_flag <= 1'b0;
      if (out_set) out_flag <= 1'b1; else if (out_put) out_flag <= 1'b0;
      if (mem_we) wr_cnt <= wr_cnt + 1;
      if (in_take) take_cnt <= take_cnt + 1;
      if (out_put) put_cnt <= put_cnt + 1;
      if (ien) ien_seen <= 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic poke(input int a, input logic [15:0] d);
    ld_en = 1'b1; ld_a = 12'(a); ld_d = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic wipe();
    for (int a = 0; a < 64; a++) poke(a, 16'h0000);
  endtask

  task automatic run(input int exp_cyc, input string req, input int in_at, input int out_at, output int cyc);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 3000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      in_set  = (cyc == in_at);
      out_set = (cyc == out_at);
    end
    in_set = 1'b0; out_set = 1'b0;
    chk(halted, req, 32'(halted), 1);
    if (exp_cyc > 0) chk(cyc == exp_cyc, "R14 cycles", 32'(cyc), 32'(exp_cyc));
  endtask

  function automatic logic [15:0] sample_val(input int k);
    case (k)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h7FFF;
      3: return 16'h8000;
      4: return 16'hFFFF;
      default: return 16'hA5C3;
    endcase
  endfunction

  function automatic logic [16:0] reg_model(input logic [15:0] op, input logic [15:0] a, input logic ev);
    if (op[11]) return {ev, 16'h0000};
    if (op[10]) return {1'b0, a};
    if (op[9])  return {ev, ~a};
    if (op[8])  return {~ev, a};
    if (op[7])  return {a[0], ev, a[15:1]};
    if (op[6])  return {a[15], a[14:0], ev};
    if (op[5])  return {ev, a + 16'd1};
    return {ev, a};
  endfunction

  initial begin
    int cyc;
    logic [15:0] a, b, av;
    logic [16:0] s, m;
    logic [15:0] ops [0:8];
    logic [15:0] sk [0:3];
    bit do_skip;

    @(negedge clk);
    // R1 reset state
    chk(mem_addr == 12'd0 && !mem_we, "R1 addr/we in reset", {20'h0, mem_addr}, 0);
    chk(!halted && !ien && out_char == 8'h00, "R1 outputs in reset", {halted, ien, out_char}, 0);

    // R2 R3 R14: ADD and AND sweeps
    wipe();
    for (int op = 0; op < 2; op++) begin
      for (int i = 0; i < 16; i++) begin
        a = 16'((i * 4951 + (i % 3) * 32769) & 32'hFFFF);
        b = 16'((65535 - i * 2877) & 32'hFFFF);
        poke(0, 16'h2010); poke(1, (op == 0) ? 16'h1011 : 16'h0011); poke(2, 16'h3012);
        poke(3, 16'h7800); poke(4, 16'h7040); poke(5, 16'h3013); poke(6, 16'h7001);
        poke(16, a); poke(17, b); poke(18, 16'h0); poke(19, 16'h0);
        run(18, "R14 add program", -1, -1, cyc);
        if (op == 0) begin
          s = {1'b0, a} + {1'b0, b};
          chk(mem[18] == s[15:0], "R3 add sum", {16'h0, mem[18]}, {16'h0, s[15:0]});
          chk(mem[19] == {15'h0, s[16]}, "R3 add carry", {16'h0, mem[19]}, {31'h0, s[16]});
        end else begin
          chk(mem[18] == (a & b), "R2 and result", {16'h0, mem[18]}, {16'h0, a & b});
          chk(mem[19] == 16'h0, "R3 and keeps E", {16'h0, mem[19]}, 0);
        end
      end
    end

    // R1: first cycle after reset
    rst_n = 1'b0; @(negedge clk);
    chk(!halted, "R1 halted clears in reset", 32'(halted), 0);
    rst_n = 1'b1;
    chk(mem_addr == 12'd0 && !mem_we, "R1 first fetch at 0", {20'h0, mem_addr}, 0);

    // R4 indirect
    wipe();
    poke(0, 16'hA010); poke(1, 16'h3011); poke(2, 16'hB012); poke(3, 16'h7001);
    poke(16, 16'h1020); poke(18, 16'hF030); poke(32, 16'hBEEF);
    run(13, "R4 indirect program", -1, -1, cyc);
    chk(mem[17] == 16'hBEEF, "R4 indirect load", {16'h0, mem[17]}, 32'hBEEF);
    chk(mem[48] == 16'hBEEF, "R4 indirect store", {16'h0, mem[48]}, 32'hBEEF);
    chk(mem[18] == 16'hF030, "R4 pointer untouched", {16'h0, mem[18]}, 32'hF030);

    // R5 call and return
    wipe();
    poke(0, 16'h5010); poke(1, 16'h3030); poke(2, 16'h7001);
    poke(17, 16'h2020); poke(18, 16'hC010); poke(32, 16'h1234);
    run(15, "R5 call program", -1, -1, cyc);
    chk(mem[16] == 16'h0001, "R5 return address", {16'h0, mem[16]}, 1);
    chk(mem[48] == 16'h1234, "R5 resumed after call", {16'h0, mem[48]}, 32'h1234);

    // R6 counting loop
    wipe();
    poke(0, 16'h6010); poke(1, 16'h4000); poke(2, 16'h7001); poke(16, 16'hFFFD);
    run(20, "R6 isz loop", -1, -1, cyc);
    chk(mem[16] == 16'h0000, "R6 counter reached zero", {16'h0, mem[16]}, 0);

    // R6 single increment sweep
    for (int k = 0; k < 6; k++) begin
      av = sample_val(k);
      wipe();
      poke(0, 16'h6010); poke(1, 16'h2011); poke(2, 16'h3012); poke(3, 16'h7001);
      poke(16, av); poke(17, 16'h5A5A); poke(18, 16'h1111);
      do_skip = (av == 16'hFFFF);
      run(do_skip ? 9 : 12, "R6 isz single", -1, -1, cyc);
      chk(mem[16] == av + 16'd1, "R6 written back", {16'h0, mem[16]}, {16'h0, av + 16'd1});
      chk(mem[18] == (do_skip ? 16'h0000 : 16'h5A5A), "R6 skip decision", {16'h0, mem[18]},
          do_skip ? 32'h0 : 32'h5A5A);
    end

    // R7 R13 register group sweep
    ops[0] = 16'h7800; ops[1] = 16'h7400; ops[2] = 16'h7200; ops[3] = 16'h7100;
    ops[4] = 16'h7080; ops[5] = 16'h7040; ops[6] = 16'h7020; ops[7] = 16'h7820; ops[8] = 16'h7021;
    for (int o = 0; o < 9; o++) begin
      for (int k = 0; k < 6; k++) begin
        for (int ev = 0; ev < 2; ev++) begin
          av = sample_val(k);
          wipe();
          poke(0, 16'h2010); poke(1, 16'h7400); poke(2, (ev == 1) ? 16'h7100 : 16'h7400);
          poke(3, ops[o]); poke(4, 16'h3011); poke(5, 16'h7800); poke(6, 16'h7040);
          poke(7, 16'h3012); poke(8, 16'h7001); poke(16, av);
          run(21, (o >= 7) ? "R13 multi-bit" : "R7 register op", -1, -1, cyc);
          m = reg_model(ops[o], av, 1'(ev));
          chk(mem[17] == m[15:0], (o >= 7) ? "R13 acc" : "R7 acc", {16'h0, mem[17]}, {16'h0, m[15:0]});
          chk(mem[18] == {15'h0, m[16]}, (o >= 7) ? "R13 flag" : "R7 flag", {16'h0, mem[18]}, {31'h0, m[16]});
        end
      end
    end

    // R8 skip sweep
    sk[0] = 16'h7010; sk[1] = 16'h7008; sk[2] = 16'h7004; sk[3] = 16'h7002;
    for (int q = 0; q < 4; q++) begin
      for (int k = 0; k < 6; k++) begin
        for (int ev = 0; ev < 2; ev++) begin
          av = sample_val(k);
          wipe();
          poke(0, 16'h2010); poke(1, 16'h7400); poke(2, (ev == 1) ? 16'h7100 : 16'h7400);
          poke(3, sk[q]); poke(4, 16'h2011); poke(5, 16'h3012); poke(6, 16'h7001);
          poke(16, av); poke(17, 16'h0C0C);
          case (q)
            0: do_skip = !av[15];
            1: do_skip = av[15];
            2: do_skip = (av == 16'h0);
            default: do_skip = (ev == 0);
          endcase
          run(do_skip ? 14 : 17, "R8 skip program", -1, -1, cyc);
          chk(mem[18] == (do_skip ? av : 16'h0C0C), "R8 skip result", {16'h0, mem[18]},
              {16'h0, do_skip ? av : 16'h0C0C});
        end
      end
    end

    // R9 R10 R11 input/output
    wipe();
    poke(0, 16'h2011); poke(1, 16'hF200); poke(2, 16'h4001); poke(3, 16'hF800);
    poke(4, 16'hF400); poke(5, 16'h3010); poke(6, 16'hF080); poke(7, 16'h7001);
    poke(17, 16'hAB00);
    in_char = 8'h5C;
    run(0, "R9 io program", 30, -1, cyc);
    chk(cyc > 30, "R10 SKI waits for flag", 32'(cyc), 31);
    chk(mem[16] == 16'hAB5C, "R9 input low byte only", {16'h0, mem[16]}, 32'hAB5C);
    chk(out_char == 8'h5C, "R9 output char", {24'h0, out_char}, 32'h5C);
    chk(take_cnt == 1 && put_cnt == 1, "R9 strobes once", 32'(take_cnt * 16 + put_cnt), 32'h11);
    chk(!in_flag, "R9 input flag cleared", 32'(in_flag), 0);
    chk(ien, "R11 ion", 32'(ien), 1);

    wipe();
    poke(0, 16'hF100); poke(1, 16'h4000); poke(2, 16'hF080); poke(3, 16'hF040);
    poke(4, 16'hF400); poke(5, 16'h7001);
    run(0, "R10 sko program", -1, 25, cyc);
    chk(cyc > 25, "R10 SKO waits for flag", 32'(cyc), 26);
    chk(!ien && ien_seen, "R11 ion then iof", {ien, ien_seen}, 1);
    chk(!out_flag && put_cnt == 1, "R9 output flag cleared", {out_flag, 8'(put_cnt)}, 1);

    // R12 halt is final
    wipe();
    poke(0, 16'h7001); poke(1, 16'h3010); poke(2, 16'h7800); poke(16, 16'h7777);
    run(2, "R12 halt program", -1, -1, cyc);
    repeat (20) @(negedge clk);
    chk(halted, "R12 stays halted", 32'(halted), 1);
    chk(mem[16] == 16'h7777 && wr_cnt == 0, "R12 no write after halt", {16'h0, mem[16]}, 32'h7777);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule